// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a RAM with one read-only port and one write-only port on a single clock. The two ports address the same flat array of bits, but each port has its own data width chosen from 1, 2, 4, 9, 18 or 36. A port's address is counted in units of that port's own width. An access at address `a` on a port of width `w` therefore covers array bits `a*w` through `a*w+w-1`. A narrow port can then pick single bytes out of a word that a wide port wrote, or the reverse.

Widths 9, 18 and 36 carry one extra bit per 8-bit byte. The extra bit is stored and returned exactly like a data bit. When both ports use such widths, all bits are kept. When either port is narrower than 9, the extra bits are dropped and the wider port becomes 8, 16 or 32 bits wide. The parameters are the array size in bits and the two nominal widths. Each port's address width follows from those.

A wide write port has one byte enable per byte lane. Each lane covers 8 data bits plus, where present, the extra bit. The block raises a one-cycle flag when a read and a write touch overlapping bits on the same edge. The read data of that cycle must then be discarded.

Top module: `sdp_asym_ram`

## Requirements
- R1: With the default widths (read 9, write 36), the read port returns 9 bits and the write port takes 36 bits. Bit 8 of every 9-bit unit is stored and returned unchanged.
- R2: Read address `a` returns array bits `a*9`..`a*9+8`. Byte lane `l` (data bits `l*9`..`l*9+8`) of a write to word `w` is stored at read address `4*w+l`.
- R3: Write-enable bit `l` controls lane `l` alone. A lane whose enable is low keeps its previous contents.
- R4: A read with `rd_en` high presents its data on `rd_data` one clock edge later.
- R5: While `rd_en` is low, `rd_data` keeps its value.
- R6: When `rd_en` and `wr_en` are both high and the read range overlaps the write word, `collision` is high for exactly the following cycle.
- R7: `collision` stays low when either enable is low or the two ranges do not overlap. With no collision, a same-edge read of other bits returns correct data.
- R8: After the active-low reset, `rd_data` and `collision` are zero and every array bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | RAW (5) | Read address in read-width units |
| rd_data | output | ERW (9) | Registered read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | WAW (3) | Write address in write-width units |
| wr_be | input | NBE (4) | Per-lane write enables |
| wr_data | input | EWW (36) | Write data |
| collision | output | 1 | Same-edge overlap of read and write, one cycle |

## Verification
The hardest case to reach from the ports is a same-edge collision in which only part of the word is enabled. Random addresses rarely line up, so the stimulus draws read addresses near the write word on purpose. A read and a write at neighbouring addresses exercise the boundary of the overlap test. A read of 9-bit units inside a word written with a sparse lane mask shows whether each extra bit lands in the lane it belongs to.

// File: rtl/asym_ram_pkg.sv
// Package: width arithmetic shared by the mixed-width RAM.
// Assumes widths come from the set 1, 2, 4, 9, 18, 36.
package asym_ram_pkg;

    // Effective stored width of a port; drops the extra bits if the other port is narrow.
    function automatic int eff_width(input int w, input int other);
        if (w >= 9 && other < 9) return (w / 9) * 8;
        return w;
    endfunction

    // Number of byte lanes (write enables) on a port of nominal width w.
    function automatic int lane_count(input int w);
        return (w >= 9) ? (w / 9) : 1;
    endfunction

    // Address width for a given depth, never below one bit.
    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/asym_wr_decode.sv
// Turns a write request into a full-array bit mask and aligned data.
// Assumes CAP_BITS is a multiple of EWW and that NBE lanes of LW bits tile EWW.
module asym_wr_decode #(
    parameter int CAP_BITS = 288,
    parameter int EWW      = 36,
    parameter int NBE      = 4,
    parameter int WAW      = 3
) (
    input  logic                wr_en,
    input  logic [WAW-1:0]      wr_addr,
    input  logic [NBE-1:0]      wr_be,
    input  logic [EWW-1:0]      wr_data,
    output logic [CAP_BITS-1:0] bit_mask,
    output logic [CAP_BITS-1:0] bit_data
);
    localparam int LW = EWW / NBE;

    logic [EWW-1:0] word_mask;

    // Expand each lane enable across the bits of its lane.
    for (genvar l = 0; l < NBE; l++) begin : g_lane
        assign word_mask[l*LW +: LW] = {LW{wr_be[l] & wr_en}};
    end

    // Shift mask and data to the word's position in the array.
    always_comb begin
        bit_mask = {{(CAP_BITS-EWW){1'b0}}, word_mask} << (int'(wr_addr) * EWW);
        bit_data = {{(CAP_BITS-EWW){1'b0}}, wr_data}   << (int'(wr_addr) * EWW);
    end
endmodule

// File: rtl/asym_bit_store.sv
// Flat bit array with masked write and registered, width-sliced read.
// Assumes reset clears contents; read sees pre-write contents on the same edge.
module asym_bit_store #(
    parameter int CAP_BITS = 288,
    parameter int ERW      = 9,
    parameter int RAW      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAP_BITS-1:0] bit_mask,
    input  logic [CAP_BITS-1:0] bit_data,
    input  logic                rd_en,
    input  logic [RAW-1:0]      rd_addr,
    output logic [ERW-1:0]      rd_q
);
    logic [CAP_BITS-1:0] cells;

    // Update only the bits selected by the write mask.
    always_ff @(posedge clk) begin
        if (!rst_n) cells <= '0;
        else        cells <= (cells & ~bit_mask) | (bit_data & bit_mask);
    end

    // Capture the addressed slice when a read is requested, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= ERW'(cells >> (int'(rd_addr) * ERW));
    end
endmodule

// File: rtl/asym_overlap_flag.sv
// Flags a same-edge read and write whose bit ranges overlap; one-cycle pulse.
// Assumes both addresses are in range for their widths.
module asym_overlap_flag #(
    parameter int ERW = 9,
    parameter int EWW = 36,
    parameter int RAW = 5,
    parameter int WAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_en,
    input  logic [RAW-1:0] rd_addr,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_addr,
    output logic           flag
);
    int  rd_lo, wr_lo;
    logic hit;

    // Compare the half-open bit ranges of the two accesses.
    always_comb begin
        rd_lo = int'(rd_addr) * ERW;
        wr_lo = int'(wr_addr) * EWW;
        hit   = (rd_lo < wr_lo + EWW) && (wr_lo < rd_lo + ERW);
    end

    // Register the flag so it lines up with the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= rd_en && wr_en && hit;
    end
endmodule

// File: rtl/sdp_asym_ram.sv
// Top: read-only port A and write-only port B of differing widths on one array.
// Assumes a single clock and CAP_BITS divisible by both effective widths.
module sdp_asym_ram
    import asym_ram_pkg::*;
#(
    parameter  int CAP_BITS = 288,
    parameter  int RD_W     = 9,
    parameter  int WR_W     = 36,
    localparam int ERW      = eff_width(RD_W, WR_W),
    localparam int EWW      = eff_width(WR_W, RD_W),
    localparam int RAW      = addr_bits(CAP_BITS / ERW),
    localparam int WAW      = addr_bits(CAP_BITS / EWW),
    localparam int NBE      = lane_count(WR_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_en,
    input  logic [RAW-1:0] rd_addr,
    output logic [ERW-1:0] rd_data,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_addr,
    input  logic [NBE-1:0] wr_be,
    input  logic [EWW-1:0] wr_data,
    output logic           collision
);
    logic [CAP_BITS-1:0] bit_mask;
    logic [CAP_BITS-1:0] bit_data;

    asym_wr_decode #(.CAP_BITS(CAP_BITS), .EWW(EWW), .NBE(NBE), .WAW(WAW)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .bit_mask(bit_mask), .bit_data(bit_data)
    );

    asym_bit_store #(.CAP_BITS(CAP_BITS), .ERW(ERW), .RAW(RAW)) u_store (
        .clk(clk), .rst_n(rst_n), .bit_mask(bit_mask), .bit_data(bit_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_data)
    );

    asym_overlap_flag #(.ERW(ERW), .EWW(EWW), .RAW(RAW), .WAW(WAW)) u_flag (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .flag(collision)
    );
endmodule

// File: rtl/sdp_asym_ram_checker.sv
// Checker bound to sdp_asym_ram: port-level timing properties.
module sdp_asym_ram_checker #(
    parameter int ERW = 9,
    parameter int EWW = 36,
    parameter int RAW = 5,
    parameter int WAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_en,
    input logic [RAW-1:0] rd_addr,
    input logic [ERW-1:0] rd_data,
    input logic           wr_en,
    input logic [WAW-1:0] wr_addr,
    input logic           collision
);
    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_flag_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en) |=> !collision);

    assert_flag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> ((int'($past(rd_addr)) * ERW) / EWW == int'($past(wr_addr))
                    || (int'($past(rd_addr)) * ERW + ERW - 1) / EWW == int'($past(wr_addr))));

    assert_reset_clear_R8: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == '0 && !collision));
endmodule

bind sdp_asym_ram sdp_asym_ram_checker #(.ERW(ERW), .EWW(EWW), .RAW(RAW), .WAW(WAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .collision(collision)
);

// File: tb/tb_sdp_asym_ram.sv
module tb_sdp_asym_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [8:0]  rd_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [35:0] wr_data = '0;
    logic        collision;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] ref_unit [32];
    logic [8:0] last_rd = '0;
    bit         last_ok = 1'b1;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sdp_asym_ram dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .collision(collision)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit overlaps(input int ra, input int wa);
        return (ra / 4) == wa;
    endfunction

    // One access cycle: drive at negedge, sample just after the capturing edge.
    task automatic op(input bit re, input int ra, input bit we, input int wa,
                      input logic [35:0] wd, input logic [3:0] be, input string tag);
        bit coll_exp;
        logic [8:0] rd_exp;
        @(negedge clk);
        rd_en = re; rd_addr = 5'(ra); wr_en = we; wr_addr = 3'(wa);
        wr_data = wd; wr_be = be;
        coll_exp = re && we && overlaps(ra, wa);
        rd_exp = ref_unit[ra];
        @(posedge clk);
        #1;
        check({tag, " collision R6/R7"}, 36'(collision), 36'(coll_exp));
        if (re && !coll_exp) begin
            check({tag, " read data R4"}, 36'(rd_data), 36'(rd_exp));
            last_rd = rd_exp; last_ok = 1'b1;
        end else if (re) begin
            last_ok = 1'b0;
        end else if (last_ok) begin
            check({tag, " hold R5"}, 36'(rd_data), 36'(last_rd));
        end
        if (we)
            for (int l = 0; l < 4; l++)
                if (be[l]) ref_unit[wa*4 + l] = wd[l*9 +: 9];
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) ref_unit[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("reset rd_data R8", 36'(rd_data), 36'h0);
        check("reset collision R8", 36'(collision), 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: contents read back as zero after reset.
        op(1, 17, 0, 0, '0, '0, "R8 cleared");
        // R1/R2: full word write, then each 9-bit unit with its extra bit.
        op(0, 0, 1, 3, 36'h1_2345_6789 | 36'h8_0000_0000 | 36'h0_0000_0100, 4'hF, "R2 wr");
        for (int l = 0; l < 4; l++) op(1, 12 + l, 0, 0, '0, '0, "R1 R2 unit");
        // R3: sparse lanes keep unwritten lanes.
        op(0, 0, 1, 3, 36'hF_FFFF_FFFF, 4'b0101, "R3 wr");
        for (int l = 0; l < 4; l++) op(1, 12 + l, 0, 0, '0, '0, "R3 unit");
        // R5: idle cycles hold last read.
        op(0, 5, 0, 0, '0, '0, "R5 idle");
        op(0, 5, 1, 1, 36'hA_BCDE_F012, 4'hF, "R5 idle wr");
        // R6: collision with partial enable, then R7 neighbour read.
        op(1, 13, 1, 3, 36'h5_5555_5555, 4'b0010, "R6 coll");
        op(1, 11, 1, 3, 36'h3_3333_3333, 4'hF, "R7 neighbour");
        op(1, 16, 1, 3, 36'h0_0000_0000, 4'h1, "R7 upper neighbour");
        op(1, 13, 0, 3, '0, '0, "R7 read only");
        // Random mix biased toward the write word.
        for (int i = 0; i < 600; i++) begin
            int wa = int'($urandom_range(7));
            int ra = ($urandom_range(3) == 0) ? wa*4 + int'($urandom_range(3))
                                               : int'($urandom_range(31));
            logic [35:0] wd = {$urandom, $urandom};
            op(bit'($urandom_range(1)), ra, bit'($urandom_range(1)), wa, wd,
               4'($urandom_range(15)), "random R2 R3");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule